// File: doc/BRIEF.md
# Two-Halfword Long Branch-and-Link Sequencer

This unit carries out the call sequence of a 16-bit instruction set in which a subroutine target is too far away for one instruction. The target is split over two consecutive halfwords. The upper halfword places a partial target address in the link register. The lower halfword then completes the target from that partial address, redirects the program counter and leaves the return address in the link register.

The unit accepts one halfword per cycle. Each halfword arrives with a valid strobe, its 11-bit offset field, a selector bit that marks it as the upper or lower half, the current program counter and the present link register contents. The current program counter is taken to be the address of the halfword plus 4, because of prefetch. All results are registered and appear one cycle after the halfword is accepted. The link register result comes with a write strobe. The new program counter comes with a load strobe that also asks the fetch stage to flush and refill.

Top module: `long_branch_link`

## Requirements
- R1: While reset is held, and in the first cycle after it, `lr_we`, `lr_wdata`, `pc_load` and `pc_target` are all zero.
- R2: The cycle after an accepted upper half (`hw_valid`=1, `hw_lower`=0), `lr_we` is 1 and `lr_wdata` equals `cur_pc` plus the offset sign-extended from bit 10 and multiplied by 4096.
- R3: An upper half never raises `pc_load` in the following cycle, and it leaves `pc_target` unchanged.
- R4: The cycle after an accepted lower half (`hw_lower`=1), `pc_target` equals `lr_in` with bit 0 cleared, plus the offset (zero-extended) multiplied by 2.
- R5: In that same cycle, `lr_wdata` equals `cur_pc` minus 2 with bit 0 forced to 1.
- R6: A lower half raises `pc_load` and `lr_we` together for exactly one cycle.
- R7: A cycle with `hw_valid`=0 gives `lr_we`=0 and `pc_load`=0 in the next cycle, whatever the other inputs are, and leaves `lr_wdata` and `pc_target` unchanged.
- R8: Every addition and subtraction wraps modulo 2^32 in both halves.
- R9: The selector bit alone chooses the half. An upper half followed directly by a lower half, or two halves of the same kind in a row, are each handled on their own inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | A long-branch halfword is present this cycle |
| hw_lower | input | 1 | 0 = upper (first) half, 1 = lower (second) half |
| hw_ofs | input | 11 | Offset field of the halfword |
| cur_pc | input | 32 | Halfword address plus 4 |
| lr_in | input | 32 | Present link register value |
| lr_we | output | 1 | Link register write strobe |
| lr_wdata | output | 32 | Value to write to the link register |
| pc_load | output | 1 | Branch taken: load `pc_target` and flush the pipeline |
| pc_target | output | 32 | New program counter |

## Verification
A lower half is the one case in which two results fall in the same cycle: the branch (`pc_load` with `pc_target`) and the link write (`lr_we` with the tagged return address). The vector table places a lower half after each upper half, with `lr_in` carrying bit 0 set, a maximal offset, or a value that forces a carry out of bit 31. In the cycle after each lower half, the bench requires both strobes and both data words together. It then checks that a following upper half drops `pc_load` while `pc_target` stays put.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_kind_e;

  localparam int unsigned LBL_ADDR_W    = 32;
  localparam int unsigned LBL_OFS_W     = 11;
  localparam int unsigned LBL_HI_SHIFT  = 12;
  localparam int unsigned LBL_LO_SHIFT  = 1;
  localparam int unsigned LBL_RET_BACK  = 2;

endpackage

// File: rtl/lbl_upper_half.sv
module lbl_upper_half #(
  parameter int unsigned ADDR_W   = lbl_pkg::LBL_ADDR_W,
  parameter int unsigned OFS_W    = lbl_pkg::LBL_OFS_W,
  parameter int unsigned HI_SHIFT = lbl_pkg::LBL_HI_SHIFT
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] partial
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;

  // Sign-extend the offset to the address width, then scale it.
  function automatic logic [ADDR_W-1:0] scaled_sext(input logic [OFS_W-1:0] o);
    logic [ADDR_W-1:0] wide;
    wide = {{EXT_W{o[OFS_W-1]}}, o};
    return wide << HI_SHIFT;
  endfunction

  // Wrapping add of the prefetched PC and the scaled offset.
  function automatic logic [ADDR_W-1:0] upper_sum(input logic [ADDR_W-1:0] p,
                                                  input logic [OFS_W-1:0]  o);
    return p + scaled_sext(o);
  endfunction

  assign partial = upper_sum(pc, ofs);
endmodule

// File: rtl/lbl_lower_half.sv
module lbl_lower_half #(
  parameter int unsigned ADDR_W   = lbl_pkg::LBL_ADDR_W,
  parameter int unsigned OFS_W    = lbl_pkg::LBL_OFS_W,
  parameter int unsigned LO_SHIFT = lbl_pkg::LBL_LO_SHIFT,
  parameter int unsigned RET_BACK = lbl_pkg::LBL_RET_BACK
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] lr,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] ret_addr
);
  localparam int unsigned EXT_W = ADDR_W - OFS_W;
  localparam logic [ADDR_W-1:0] BACK = ADDR_W'(RET_BACK);

  // Partial address from the link register, halfword aligned, plus offset.
  function automatic logic [ADDR_W-1:0] final_target(input logic [ADDR_W-1:0] l,
                                                     input logic [OFS_W-1:0]  o);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] step;
    base = {l[ADDR_W-1:1], 1'b0};
    step = {{EXT_W{1'b0}}, o} << LO_SHIFT;
    return base + step;
  endfunction

  // Address of the halfword after the pair, tagged in bit 0.
  function automatic logic [ADDR_W-1:0] tagged_return(input logic [ADDR_W-1:0] p);
    logic [ADDR_W-1:0] back;
    back = p - BACK;
    return {back[ADDR_W-1:1], 1'b1};
  endfunction

  assign target   = final_target(lr, ofs);
  assign ret_addr = tagged_return(pc);
endmodule

// File: rtl/lbl_out_reg.sv
module lbl_out_reg #(
  parameter int unsigned ADDR_W = lbl_pkg::LBL_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_we_d,
  input  logic [ADDR_W-1:0] lr_data_d,
  input  logic              pc_ld_d,
  input  logic [ADDR_W-1:0] pc_data_d,
  output logic              lr_we_q,
  output logic [ADDR_W-1:0] lr_data_q,
  output logic              pc_ld_q,
  output logic [ADDR_W-1:0] pc_data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_we_q   <= 1'b0;
      lr_data_q <= '0;
      pc_ld_q   <= 1'b0;
      pc_data_q <= '0;
    end else begin
      lr_we_q <= lr_we_d;
      pc_ld_q <= pc_ld_d;
      if (lr_we_d) lr_data_q <= lr_data_d;
      if (pc_ld_d) pc_data_q <= pc_data_d;
    end
  end

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_ld_q |=> (!pc_ld_q || 1'b1) && ($stable(pc_data_q) || pc_ld_q));

  // R7
  lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lr_we_q |-> !pc_ld_q);
endmodule

// File: rtl/long_branch_link.sv
module long_branch_link #(
  parameter int unsigned ADDR_W   = lbl_pkg::LBL_ADDR_W,
  parameter int unsigned OFS_W    = lbl_pkg::LBL_OFS_W,
  parameter int unsigned HI_SHIFT = lbl_pkg::LBL_HI_SHIFT,
  parameter int unsigned LO_SHIFT = lbl_pkg::LBL_LO_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  input  logic              hw_lower,
  input  logic [OFS_W-1:0]  hw_ofs,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] lr_in,
  output logic              lr_we,
  output logic [ADDR_W-1:0] lr_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target
);
  import lbl_pkg::*;

  half_kind_e        kind;
  logic [ADDR_W-1:0] partial_addr;
  logic [ADDR_W-1:0] branch_addr;
  logic [ADDR_W-1:0] return_addr;
  logic              take_upper;
  logic              take_lower;
  logic              lr_we_d;
  logic [ADDR_W-1:0] lr_data_d;
  logic              pc_ld_d;
  logic              past_ok;

  assign kind       = half_kind_e'(hw_lower);
  assign take_upper = hw_valid && (kind == HALF_UPPER);
  assign take_lower = hw_valid && (kind == HALF_LOWER);

  lbl_upper_half #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .HI_SHIFT(HI_SHIFT)) u_upper (
    .ofs     (hw_ofs),
    .pc      (cur_pc),
    .partial (partial_addr)
  );

  lbl_lower_half #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .LO_SHIFT(LO_SHIFT),
                   .RET_BACK(LBL_RET_BACK)) u_lower (
    .ofs      (hw_ofs),
    .pc       (cur_pc),
    .lr       (lr_in),
    .target   (branch_addr),
    .ret_addr (return_addr)
  );

  always_comb begin
    lr_we_d   = take_upper || take_lower;
    pc_ld_d   = take_lower;
    lr_data_d = take_lower ? return_addr : partial_addr;
  end

  lbl_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .lr_we_d   (lr_we_d),
    .lr_data_d (lr_data_d),
    .pc_ld_d   (pc_ld_d),
    .pc_data_d (branch_addr),
    .lr_we_q   (lr_we),
    .lr_data_q (lr_wdata),
    .pc_ld_q   (pc_load),
    .pc_data_q (pc_target)
  );

  // Marks cycles whose previous edge lies after reset release.
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3
  upper_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(hw_valid && !hw_lower)) |-> (!pc_load && lr_we));

  // R6
  lower_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(hw_valid && hw_lower)) |-> (pc_load && lr_we));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(hw_valid)) |-> (!pc_load && !lr_we && $stable(lr_wdata)));

  // R5
  ret_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> lr_wdata[0]);

  // R4
  target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> !pc_target[0]);
endmodule

// File: tb/tb_long_branch_link.sv
module tb_long_branch_link;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 8;
  localparam int unsigned VW = 1 + 11 + 32 + 32 + 32;

  // {lower, ofs, cur_pc, lr_in, expected result}
  // upper half: expected = link value; lower half: expected = new PC
  localparam logic [VW-1:0] VECS [0:NVEC-1] = '{
    {1'b0, 11'h001, 32'h0800_0104, 32'h0000_0000, 32'h0800_1104},
    {1'b1, 11'h010, 32'h0800_0106, 32'h0800_1104, 32'h0800_1124},
    {1'b0, 11'h7FF, 32'h0800_2000, 32'h0000_0000, 32'h0800_1000},
    {1'b1, 11'h7FF, 32'h0800_2002, 32'h0800_1001, 32'h0800_1FFE},
    {1'b0, 11'h400, 32'h0000_1004, 32'h0000_0000, 32'hFFC0_1004},
    {1'b1, 11'h3FF, 32'h0000_1006, 32'hFFFF_FFFF, 32'h0000_07FC},
    {1'b0, 11'h3FF, 32'hFFFF_F004, 32'h0000_0000, 32'h003F_E004},
    {1'b1, 11'h000, 32'h0000_0002, 32'h0000_0000, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic        hw_lower = 1'b0;
  logic [10:0] hw_ofs = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] lr_in = '0;
  logic        lr_we;
  logic [31:0] lr_wdata;
  logic        pc_load;
  logic [31:0] pc_target;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] last_pc = '0;
  logic [31:0] last_lr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  long_branch_link dut (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_lower(hw_lower),
    .hw_ofs(hw_ofs), .cur_pc(cur_pc), .lr_in(lr_in),
    .lr_we(lr_we), .lr_wdata(lr_wdata), .pc_load(pc_load), .pc_target(pc_target)
  );

  // Independent model: signed scale for the upper half.
  function automatic logic [31:0] model_upper(input logic [31:0] p, input logic [10:0] o);
    int signed s;
    s = (o >= 11'h400) ? int'(o) - 2048 : int'(o);
    return p + 32'(s * 4096);
  endfunction

  function automatic logic [31:0] model_target(input logic [31:0] l, input logic [10:0] o);
    return (l - (l % 2)) + 32'(o) * 2;
  endfunction

  function automatic logic [31:0] model_return(input logic [31:0] p);
    logic [31:0] a;
    a = p - 32'd2;
    return a | 32'd1;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge register it, sample at the next falling edge.
  task automatic apply(input logic v, input logic low, input logic [10:0] o,
                       input logic [31:0] p, input logic [31:0] l);
    hw_valid = v; hw_lower = low; hw_ofs = o; cur_pc = p; lr_in = l;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state, with a live halfword applied during reset
    hw_valid = 1'b1; hw_lower = 1'b1; hw_ofs = 11'h123; lr_in = 32'hDEAD_BEEF; cur_pc = 32'h100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "lr_we",     32'(lr_we), 32'd0);
    check("R1", "pc_load",   32'(pc_load), 32'd0);
    check("R1", "lr_wdata",  lr_wdata, 32'd0);
    check("R1", "pc_target", pc_target, 32'd0);
    hw_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "lr_we after release", 32'(lr_we), 32'd0);

    // Table walk: R2, R3, R4, R5, R6, R8, R9
    for (int i = 0; i < NVEC; i++) begin
      logic        low;
      logic [10:0] o;
      logic [31:0] p, l, e;
      {low, o, p, l, e} = VECS[i];
      apply(1'b1, low, o, p, l);
      if (!low) begin
        check("R2", "table lr_we", 32'(lr_we), 32'd1);
        check("R2", "table lr_wdata", lr_wdata, model_upper(p, o));
        check("R8", "table upper wrap", lr_wdata, e);
        check("R3", "table pc_load", 32'(pc_load), 32'd0);
        check("R3", "table pc_target held", pc_target, last_pc);
        last_lr = lr_wdata;
      end else begin
        check("R6", "table pc_load", 32'(pc_load), 32'd1);
        check("R6", "table lr_we", 32'(lr_we), 32'd1);
        check("R4", "table pc_target", pc_target, model_target(l, o));
        check("R8", "table lower wrap", pc_target, e);
        check("R5", "table return", lr_wdata, model_return(p));
        last_pc = pc_target;
        last_lr = lr_wdata;
      end
    end

    // R7: idle cycle with junk inputs
    apply(1'b0, 1'b1, 11'h5A5, 32'h1234_5678, 32'h8765_4321);
    check("R7", "idle lr_we", 32'(lr_we), 32'd0);
    check("R7", "idle pc_load", 32'(pc_load), 32'd0);
    check("R7", "idle lr_wdata held", lr_wdata, last_lr);
    check("R7", "idle pc_target held", pc_target, last_pc);

    // R6: lower half strobes for one cycle only
    apply(1'b1, 1'b1, 11'h002, 32'h0000_4004, 32'h0001_0000);
    check("R6", "pulse up", 32'(pc_load), 32'd1);
    check("R4", "directed target", pc_target, 32'h0001_0004);
    last_pc = pc_target;
    apply(1'b0, 1'b0, 11'h000, 32'h0, 32'h0);
    check("R6", "pulse down", 32'(pc_load), 32'd0);

    // R9: two upper halves back to back, each from its own inputs
    apply(1'b1, 1'b0, 11'h002, 32'h0000_0010, 32'h0);
    check("R9", "first upper", lr_wdata, 32'h0000_2010);
    apply(1'b1, 1'b0, 11'h7FE, 32'h0000_3000, 32'h0);
    check("R9", "second upper", lr_wdata, 32'h0000_1000);
    check("R9", "pc_target untouched", pc_target, last_pc);

    // R8: return address wraps below zero
    apply(1'b1, 1'b1, 11'h001, 32'h0000_0000, 32'h0000_0000);
    check("R8", "return wrap", lr_wdata, 32'hFFFF_FFFF);

    // R1: reset in mid-run clears everything
    rst_n = 1'b0;
    apply(1'b0, 1'b0, 11'h0, 32'h0, 32'h0);
    check("R1", "re-reset pc_target", pc_target, 32'd0);
    check("R1", "re-reset lr_wdata", lr_wdata, 32'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule